// File: doc/BRIEF.md
# Lane-Routed Masked Register Bank

This block is the register store of an eight-lane serial device. A host reaches it over a single-cycle bus. Every access carries an 8-bit address. A write also carries a data byte and a mask byte. Each write is a read-modify-write: only the bits set in the mask change, and the other bits keep their old contents.

The store has one shared page and one page per lane. Each page holds `PAGE_DEPTH` registers at the low addresses. Two control registers steer each access to a page:

- **Lane-select register (address 0xFC):** one bit per lane. Bit i selects lane i.
- **Page-control register (address 0xFF):** bit 0 picks the lane pages instead of the shared page. Bit 1 turns on broadcast.

With broadcast on, one write lands in every selected lane. With broadcast off, the write lands only in the lowest-numbered selected lane. Reads always come from the lowest-numbered selected lane, so read data never mixes lanes.

Read responses are sequenced by a two-state machine:

| State | Meaning | Transitions |
|---|---|---|
| `RD_IDLE` | No response pending; `rd_valid` is low | Moves to `RD_RESP` on a read strobe; otherwise stays in `RD_IDLE` |
| `RD_RESP` | `rd_valid` is high and `rdata` holds the value captured at the strobe | Stays in `RD_RESP` on another read strobe; otherwise returns to `RD_IDLE` |

Top module: `lane_bank_regs`

## Requirements
- R1: A write sets each bit whose mask bit is 1 to the corresponding data bit. Every bit whose mask bit is 0 keeps its previous value. This holds for page registers and for both control registers.
- R2: Address 0xFC is the lane-select register. Bit i set selects lane i (0x01 selects lane 0, 0x02 selects lane 1, 0xFF selects every lane). It resets to 0x01.
- R3: Address 0xFF is the page-control register.
  - With bit 0 clear, addresses 0 to PAGE_DEPTH-1 reach the shared page.
  - With bit 0 set, they reach the lane pages and leave the shared page unchanged.
- R4: With bits 0 and 1 of 0xFF both set, a page write updates every lane whose select bit is set, using the same mask on each lane. Unselected lanes are left unchanged.
- R5: With bit 0 of 0xFF set and bit 1 clear, a page write updates only the lowest-numbered selected lane.
- R6: In lane mode, a read returns the register of the lowest-numbered selected lane. If no lane is selected, a read returns 0x00 and a write changes nothing.
- R7: Addresses 0xFC and 0xFF are always shared. They are written and read the same way whatever the page-control value.
- R8: After reset, every register is 0x00 except 0xFC, which is 0x01, and `rd_valid` is low.
- R9: Read timing:
  - Read data appears on `rdata` with `rd_valid` high in the cycle after the read strobe.
  - `rd_valid` is low in any cycle that follows a cycle without a strobe.
  - A read and a write to the same address in one cycle return the value from before the write.
- R10: Addresses from PAGE_DEPTH to 0xFB, plus 0xFD and 0xFE, hold no register. Writes to them have no effect and reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wmask | input | 8 | Write bit mask; a 1 lets that bit change |
| rdata | output | 8 | Read data, valid while rd_valid is high |
| rd_valid | output | 1 | High in the cycle after a read strobe |

## Verification
The checks use the same page address under several routing patterns:

- **Shared page against lane pages:** writing the same address in each mode shows that bit 0 of 0xFF separates the two stores.
- **Multi-lane selections with and without broadcast:** reading lanes back one at a time distinguishes broadcast fan-out from lowest-lane-only writes.
- **Partial masks on broadcast writes:** lanes that held different values show that the merge is done per lane, not copied from one lane.
- **Edge patterns:** an empty selection, masked writes to the control registers, a read and a write in the same cycle, and unmapped addresses each cover one remaining corner.

// File: rtl/lanebank_pkg.sv
package lanebank_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 8;
    localparam logic [ADDR_W-1:0] ADDR_LANESEL = 8'hFC;
    localparam logic [ADDR_W-1:0] ADDR_PAGECTL = 8'hFF;
    localparam int unsigned PCTL_LANE_BIT  = 0;
    localparam int unsigned PCTL_BCAST_BIT = 1;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    function automatic logic [DATA_W-1:0] mask_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [DATA_W-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction
endpackage

// File: rtl/lb_route.sv
module lb_route #(
    parameter int unsigned NUM_LANES  = 8,
    parameter int unsigned PAGE_DEPTH = 32,
    localparam int unsigned LW    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    localparam int unsigned IDX_W = (PAGE_DEPTH > 1) ? $clog2(PAGE_DEPTH) : 1
) (
    input  logic                               wr_en,
    input  logic [lanebank_pkg::ADDR_W-1:0]    addr,
    input  logic                               lane_mode,
    input  logic                               bcast,
    input  logic [NUM_LANES-1:0]               lanesel,
    output logic                               in_page,
    output logic [IDX_W-1:0]                   page_idx,
    output logic                               shared_we,
    output logic [NUM_LANES-1:0]               lane_we,
    output logic [LW-1:0]                      lo_lane,
    output logic                               lo_found
);
    always_comb begin
        lo_found = 1'b0;
        lo_lane  = '0;
        for (int i = NUM_LANES - 1; i >= 0; i--) begin
            if (lanesel[i]) begin
                lo_found = 1'b1;
                lo_lane  = LW'(i);
            end
        end
    end

    assign in_page   = (32'(addr) < PAGE_DEPTH);
    assign page_idx  = addr[IDX_W-1:0];
    assign shared_we = wr_en && in_page && !lane_mode;

    always_comb begin
        for (int i = 0; i < NUM_LANES; i++) begin
            lane_we[i] = wr_en && in_page && lane_mode &&
                         (bcast ? lanesel[i] : (lo_found && (lo_lane == LW'(i))));
        end
    end
endmodule

// File: rtl/lb_page.sv
module lb_page #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] wmask,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we) begin
            regs[idx] <= lanebank_pkg::mask_merge(regs[idx], wdata, wmask);
        end
    end

    assign rd_data = regs[idx];

    // R1: bits outside the mask survive a write
    assert_unmasked_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((regs[$past(idx)] & ~$past(wmask)) == ($past(regs[idx]) & ~$past(wmask))));
endmodule

// File: rtl/lb_rd_fsm.sv
module lb_rd_fsm #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_value,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid
);
    import lanebank_pkg::*;

    rd_state_e state_q, state_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        unique case (state_q)
            RD_IDLE: state_d = rd_en ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_en ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_value;
    end

    assign rdata    = rdata_q;
    assign rd_valid = (state_q == RD_RESP);

    // R9: response one cycle after the strobe, and only then
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

// File: rtl/lane_bank_regs.sv
module lane_bank_regs #(
    parameter int unsigned NUM_LANES  = 8,
    parameter int unsigned PAGE_DEPTH = 32,
    parameter logic [7:0]  LANESEL_RST = 8'h01,
    localparam int unsigned DW    = lanebank_pkg::DATA_W,
    localparam int unsigned LW    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    localparam int unsigned IDX_W = (PAGE_DEPTH > 1) ? $clog2(PAGE_DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [7:0]    addr,
    input  logic [7:0]    wdata,
    input  logic [7:0]    wmask,
    output logic [7:0]    rdata,
    output logic          rd_valid
);
    import lanebank_pkg::*;

    logic [DW-1:0]        lanesel_q, pagectl_q;
    logic                 lsel_we, pctl_we;
    logic                 in_page, shared_we, lo_found;
    logic [IDX_W-1:0]     page_idx;
    logic [NUM_LANES-1:0] lane_we;
    logic [LW-1:0]        lo_lane;
    logic [DW-1:0]        shared_rd;
    logic [DW-1:0]        lane_rd [NUM_LANES];
    logic [DW-1:0]        rd_value;

    assign lsel_we = wr_en && (addr == ADDR_LANESEL);
    assign pctl_we = wr_en && (addr == ADDR_PAGECTL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lanesel_q <= LANESEL_RST;
            pagectl_q <= '0;
        end else begin
            if (lsel_we) lanesel_q <= mask_merge(lanesel_q, wdata, wmask);
            if (pctl_we) pagectl_q <= mask_merge(pagectl_q, wdata, wmask);
        end
    end

    lb_route #(.NUM_LANES(NUM_LANES), .PAGE_DEPTH(PAGE_DEPTH)) u_route (
        .wr_en     (wr_en),
        .addr      (addr),
        .lane_mode (pagectl_q[PCTL_LANE_BIT]),
        .bcast     (pagectl_q[PCTL_BCAST_BIT]),
        .lanesel   (lanesel_q[NUM_LANES-1:0]),
        .in_page   (in_page),
        .page_idx  (page_idx),
        .shared_we (shared_we),
        .lane_we   (lane_we),
        .lo_lane   (lo_lane),
        .lo_found  (lo_found)
    );

    lb_page #(.DEPTH(PAGE_DEPTH), .DATA_W(DW)) u_shared (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (shared_we),
        .idx     (page_idx),
        .wdata   (wdata),
        .wmask   (wmask),
        .rd_data (shared_rd)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        lb_page #(.DEPTH(PAGE_DEPTH), .DATA_W(DW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (lane_we[g]),
            .idx     (page_idx),
            .wdata   (wdata),
            .wmask   (wmask),
            .rd_data (lane_rd[g])
        );
    end

    always_comb begin
        if (addr == ADDR_LANESEL)          rd_value = lanesel_q;
        else if (addr == ADDR_PAGECTL)     rd_value = pagectl_q;
        else if (!in_page)                 rd_value = '0;
        else if (pagectl_q[PCTL_LANE_BIT]) rd_value = lo_found ? lane_rd[lo_lane] : '0;
        else                               rd_value = shared_rd;
    end

    lb_rd_fsm #(.DATA_W(DW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_value (rd_value),
        .rdata    (rdata),
        .rd_valid (rd_valid)
    );

    // R5: without broadcast at most one lane page is written
    assert_single_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pagectl_q[PCTL_BCAST_BIT] |-> $onehot0(lane_we));
    // R4: no lane outside the selection is written
    assert_lane_in_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we & ~lanesel_q[NUM_LANES-1:0]) == '0);
    // R3: shared and lane pages never written together
    assert_page_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(shared_we && (lane_we != '0)));
    // R10: unmapped addresses write nothing
    assert_no_ghost_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_page) |-> (!shared_we && (lane_we == '0)));
endmodule

// File: tb/tb_lane_bank_regs.sv
module tb_lane_bank_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0, wdata = '0, wmask = '0;
    logic [7:0] rdata;
    logic       rd_valid;
    int         n_checks = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    lane_bank_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .wmask(wmask),
        .rdata(rdata), .rd_valid(rd_valid)
    );

    typedef struct packed {
        logic       rd;
        logic [3:0] req;
        logic [7:0] a;
        logic [7:0] d;
        logic [7:0] m;
        logic [7:0] e;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd2,  8'hFC, 8'h00, 8'h00, 8'h01}, // R2 select reset value
        '{1'b1, 4'd8,  8'hFF, 8'h00, 8'h00, 8'h00}, // R8 control cleared
        '{1'b1, 4'd8,  8'h05, 8'h00, 8'h00, 8'h00}, // R8 shared cleared
        '{1'b0, 4'd3,  8'h05, 8'hAA, 8'hFF, 8'h00},
        '{1'b1, 4'd3,  8'h05, 8'h00, 8'h00, 8'hAA}, // R3 shared page
        '{1'b0, 4'd1,  8'h05, 8'h55, 8'h0F, 8'h00},
        '{1'b1, 4'd1,  8'h05, 8'h00, 8'h00, 8'hA5}, // R1 masked merge
        '{1'b0, 4'd3,  8'hFF, 8'h01, 8'hFF, 8'h00},
        '{1'b1, 4'd3,  8'h05, 8'h00, 8'h00, 8'h00}, // R3 lane page separate
        '{1'b0, 4'd4,  8'hFC, 8'hFF, 8'hFF, 8'h00},
        '{1'b0, 4'd4,  8'hFF, 8'h03, 8'hFF, 8'h00},
        '{1'b0, 4'd4,  8'h10, 8'h3C, 8'hFF, 8'h00},
        '{1'b0, 4'd4,  8'hFC, 8'h02, 8'hFF, 8'h00},
        '{1'b1, 4'd4,  8'h10, 8'h00, 8'h00, 8'h3C}, // R4 lane 1 reached
        '{1'b0, 4'd4,  8'hFC, 8'h80, 8'hFF, 8'h00},
        '{1'b1, 4'd4,  8'h10, 8'h00, 8'h00, 8'h3C}, // R4 lane 7 reached
        '{1'b0, 4'd5,  8'hFF, 8'h01, 8'hFF, 8'h00},
        '{1'b0, 4'd5,  8'hFC, 8'h06, 8'hFF, 8'h00},
        '{1'b0, 4'd5,  8'h10, 8'hC3, 8'hFF, 8'h00},
        '{1'b0, 4'd5,  8'hFC, 8'h04, 8'hFF, 8'h00},
        '{1'b1, 4'd5,  8'h10, 8'h00, 8'h00, 8'h3C}, // R5 lane 2 untouched
        '{1'b0, 4'd5,  8'hFC, 8'h02, 8'hFF, 8'h00},
        '{1'b1, 4'd5,  8'h10, 8'h00, 8'h00, 8'hC3}, // R5 lane 1 written
        '{1'b0, 4'd6,  8'hFC, 8'h06, 8'hFF, 8'h00},
        '{1'b1, 4'd6,  8'h10, 8'h00, 8'h00, 8'hC3}, // R6 lowest lane read
        '{1'b0, 4'd6,  8'hFC, 8'h00, 8'hFF, 8'h00},
        '{1'b1, 4'd6,  8'h10, 8'h00, 8'h00, 8'h00}, // R6 empty select reads 0
        '{1'b0, 4'd6,  8'h10, 8'hFF, 8'hFF, 8'h00},
        '{1'b0, 4'd6,  8'hFC, 8'h02, 8'hFF, 8'h00},
        '{1'b1, 4'd6,  8'h10, 8'h00, 8'h00, 8'hC3}, // R6 empty select wrote nothing
        '{1'b1, 4'd7,  8'hFC, 8'h00, 8'h00, 8'h02}, // R7 select readable in lane mode
        '{1'b1, 4'd7,  8'hFF, 8'h00, 8'h00, 8'h01}, // R7 control readable in lane mode
        '{1'b0, 4'd7,  8'hFC, 8'h05, 8'h04, 8'h00},
        '{1'b1, 4'd7,  8'hFC, 8'h00, 8'h00, 8'h06}, // R7 R1 masked select write
        '{1'b0, 4'd4,  8'hFF, 8'h03, 8'hFF, 8'h00},
        '{1'b0, 4'd4,  8'h10, 8'h00, 8'hF0, 8'h00},
        '{1'b0, 4'd4,  8'hFC, 8'h02, 8'hFF, 8'h00},
        '{1'b1, 4'd4,  8'h10, 8'h00, 8'h00, 8'h03}, // R4 per-lane merge lane 1
        '{1'b0, 4'd4,  8'hFC, 8'h04, 8'hFF, 8'h00},
        '{1'b1, 4'd4,  8'h10, 8'h00, 8'h00, 8'h0C}, // R4 per-lane merge lane 2
        '{1'b0, 4'd3,  8'hFF, 8'h00, 8'hFF, 8'h00},
        '{1'b1, 4'd3,  8'h05, 8'h00, 8'h00, 8'hA5}, // R3 shared survived lane writes
        '{1'b0, 4'd10, 8'h20, 8'h77, 8'hFF, 8'h00},
        '{1'b1, 4'd10, 8'h20, 8'h00, 8'h00, 8'h00}, // R10 out of page
        '{1'b0, 4'd10, 8'hFD, 8'h11, 8'hFF, 8'h00},
        '{1'b1, 4'd10, 8'hFD, 8'h00, 8'h00, 8'h00}  // R10 hole near control
    };

    task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic op(input logic w, input logic r, input logic [7:0] a,
                      input logic [7:0] d, input logic [7:0] m);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; wmask = m;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(8, {7'd0, rd_valid}, 8'h00); // R8 no response after reset

        for (int i = 0; i < NV; i++) begin
            op(!VECS[i].rd, VECS[i].rd, VECS[i].a, VECS[i].d, VECS[i].m);
            check(9, {7'd0, rd_valid}, {7'd0, VECS[i].rd}); // R9 valid timing
            if (VECS[i].rd) check(int'(VECS[i].req), rdata, VECS[i].e);
        end

        // R9: read and write of one address in one cycle returns old value
        op(1'b1, 1'b1, 8'h05, 8'h00, 8'hFF);
        check(9, rdata, 8'hA5);
        check(9, {7'd0, rd_valid}, 8'h01);
        op(1'b0, 1'b1, 8'h05, 8'h00, 8'h00);
        check(9, rdata, 8'h00);
        // R9: valid falls in the idle cycle that follows
        @(negedge clk);
        check(9, {7'd0, rd_valid}, 8'h00);

        // R8: reset in mid-run restores defaults
        op(1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        op(1'b0, 1'b1, 8'hFC, 8'h00, 8'h00);
        check(8, rdata, 8'h01);
        op(1'b0, 1'b1, 8'hFF, 8'h00, 8'h00);
        check(8, rdata, 8'h00);
        op(1'b0, 1'b1, 8'h10, 8'h00, 8'h00);
        check(8, rdata, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule